// File: doc/BRIEF.md
# Banked Data Memory Addressing Unit

This block is the byte-wide data memory of a small 8-bit processor core, together with the logic that turns an instruction operand into a 12-bit location. The 4096-byte space is split into sixteen 256-byte banks. General-purpose RAM starts at address zero and grows upward to a parameterised limit. The top half of bank 15 holds the special-register region. Locations that are not implemented read as zero and ignore writes.

Every access names an 8-bit operand and one of three addressing modes. Banked direct mode puts the 4-bit bank select in front of the operand. Access mode ignores the bank select and folds the operand onto either the bottom of bank 0 or the special-register region. Indirect mode ignores the operand and uses a 12-bit pointer, which reaches every location without banking.

The bank select and the pointer live at fixed special-register addresses. They are loaded by ordinary writes. There is one combinational read port and one write port that commits on the clock edge. Both ports go through the same address resolution.

Top module: `bank_mem_unit`

## Requirements
- R1: With mode code 0 (or the spare code 3) the resolved address is {bank select[3:0], operand[7:0]}.
- R2: With mode code 1 an operand of 0x00–0x7F resolves to 0x000–0x07F, and an operand of 0x80–0xFF resolves to 0xF80–0xFFF, whatever the bank select holds.
- R3: With mode code 2 the resolved address is the 12-bit pointer, and the operand is ignored. Pointer bits 7:0 are held at 0xFE9 and bits 11:8 at 0xFEA[3:0]. Writes to bits 7:4 of 0xFEA are discarded, and those bits read as 0.
- R4: The bank select lives at 0xFE0. A write keeps only data bits 3:0, and a read returns bits 7:4 as 0.
- R5: A read of an address above GPR_TOP and below 0xF80, or of any special-region address other than 0xFE0, 0xFE9 and 0xFEA, returns 0x00.
- R6: A write to an unimplemented address changes no RAM location and no control register.
- R7: Read data follows the resolved read address combinationally. A write commits on the rising clock edge only when the write enable is high.
- R8: After reset the bank select and the pointer are 0. RAM contents are not initialised by reset.
- R9: A write to the bank select or to the pointer affects address resolution from the next cycle on. A read of that register in the same cycle as the write returns its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdMode | input | 2 | Read addressing mode code |
| rdOpnd | input | 8 | Read operand |
| rdData | output | 8 | Read data, combinational |
| wrEn | input | 1 | Write enable |
| wrMode | input | 2 | Write addressing mode code |
| wrOpnd | input | 8 | Write operand |
| wrData | input | 8 | Write data |

## Verification
The bench builds the block with GPR_TOP set to 0x17F, so general-purpose RAM covers all of bank 0 and half of bank 1. With that setting the implemented-to-unimplemented boundary, 0x17F against 0x180, can be reached by a direct access through bank 1 and by a pointer access. A RAM size that is not a power of two also lets the bench test the upper half of bank 1 for address aliasing onto low locations. The default elaboration uses GPR_TOP 0x1FF.

// File: rtl/bank_mem_pkg.sv
package bank_mem_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int OPND_W = 8;
  localparam int BANK_W = ADDR_W - OPND_W;

  localparam logic [ADDR_W-1:0] SFR_BASE  = 12'hF80;
  localparam logic [ADDR_W-1:0] BSEL_ADDR = 12'hFE0;
  localparam logic [ADDR_W-1:0] PTRL_ADDR = 12'hFE9;
  localparam logic [ADDR_W-1:0] PTRH_ADDR = 12'hFEA;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_ACCESS   = 2'd1,
    MODE_INDIRECT = 2'd2,
    MODE_SPARE    = 2'd3
  } addrMode_t;

  typedef struct packed {
    logic              ramWe;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
    logic              rdRam;
  } memStrobe_t;

  function automatic logic [ADDR_W-1:0] resolveAddr(
    input addrMode_t         mode,
    input logic [OPND_W-1:0] opnd,
    input logic [BANK_W-1:0] bsel,
    input logic [ADDR_W-1:0] ptr
  );
    logic [ADDR_W-1:0] res;
    case (mode)
      MODE_ACCESS:   res = {{BANK_W{opnd[OPND_W-1]}}, opnd};
      MODE_INDIRECT: res = ptr;
      default:       res = {bsel, opnd};
    endcase
    return res;
  endfunction
endpackage

// File: rtl/bank_mem_ctrl.sv
module bank_mem_ctrl
  import bank_mem_pkg::*;
#(
  parameter int GPR_TOP = 'h1FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        rdMode,
  input  logic [OPND_W-1:0] rdOpnd,
  input  logic              wrEn,
  input  logic [1:0]        wrMode,
  input  logic [OPND_W-1:0] wrOpnd,
  input  logic [DATA_W-1:0] wrData,
  output memStrobe_t        strobe,
  output logic [DATA_W-1:0] ctrlRdData,
  output logic              ctrlRdHit
);
  localparam logic [ADDR_W-1:0] GPR_LAST = GPR_TOP[ADDR_W-1:0];
  localparam int PTRH_W = ADDR_W - OPND_W;

  logic [BANK_W-1:0] bankSel;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;

  always_comb begin
    rdAddr = resolveAddr(addrMode_t'(rdMode), rdOpnd, bankSel, ptr);
    wrAddr = resolveAddr(addrMode_t'(wrMode), wrOpnd, bankSel, ptr);
  end

  always_comb begin
    strobe.rdAddr = rdAddr;
    strobe.wrAddr = wrAddr;
    strobe.rdRam  = (rdAddr <= GPR_LAST);
    strobe.ramWe  = wrEn && (wrAddr <= GPR_LAST);
  end

  // control register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankSel <= '0;
      ptr     <= '0;
    end else if (wrEn) begin
      if (wrAddr == BSEL_ADDR) bankSel <= wrData[BANK_W-1:0];
      if (wrAddr == PTRL_ADDR) ptr[OPND_W-1:0] <= wrData;
      if (wrAddr == PTRH_ADDR) ptr[ADDR_W-1:OPND_W] <= wrData[PTRH_W-1:0];
    end
  end

  always_comb begin
    ctrlRdHit  = 1'b1;
    ctrlRdData = '0;
    if (rdAddr == BSEL_ADDR)      ctrlRdData[BANK_W-1:0] = bankSel;
    else if (rdAddr == PTRL_ADDR) ctrlRdData = ptr[OPND_W-1:0];
    else if (rdAddr == PTRH_ADDR) ctrlRdData[PTRH_W-1:0] = ptr[ADDR_W-1:OPND_W];
    else                          ctrlRdHit = 1'b0;
  end

  AST_BSEL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == BSEL_ADDR) |=> (bankSel == $past(wrData[BANK_W-1:0]))); // R4
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrAddr == PTRL_ADDR || wrAddr == PTRH_ADDR)) |=> $stable(ptr)); // R9
  AST_ACCESS_FOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdMode == 2'd1) |-> (rdAddr[OPND_W-1:0] == rdOpnd &&
      rdAddr[ADDR_W-1:OPND_W] == (rdOpnd[OPND_W-1] ? '1 : '0))); // R2
  AST_INDIRECT_PATH: assert property (@(posedge clk) disable iff (!rstN)
    (rdMode == 2'd2) |-> (rdAddr == ptr)); // R3
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdHit && rdAddr != PTRL_ADDR) |-> (ctrlRdData[DATA_W-1:BANK_W] == '0)); // R4
endmodule

// File: rtl/bank_mem_dpath.sv
module bank_mem_dpath
  import bank_mem_pkg::*;
#(
  parameter int GPR_TOP = 'h1FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ctrlRdData,
  input  logic              ctrlRdHit,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = GPR_TOP + 1;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [ADDR_W-1:0] GPR_LAST = GPR_TOP[ADDR_W-1:0];

  logic [DATA_W-1:0] mem [DEPTH];

  // general-purpose storage, deliberately without reset
  always_ff @(posedge clk) begin
    if (strobe.ramWe) mem[strobe.wrAddr[IDX_W-1:0]] <= wrData;
  end

  always_comb begin
    if (strobe.rdRam)  rdData = mem[strobe.rdAddr[IDX_W-1:0]];
    else if (ctrlRdHit) rdData = ctrlRdData;
    else               rdData = '0;
  end

  AST_RAM_WE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ramWe |-> (strobe.wrAddr <= GPR_LAST)); // R6
  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdAddr > GPR_LAST && strobe.rdAddr < SFR_BASE) |-> (rdData == '0)); // R5
endmodule

// File: rtl/bank_mem_unit.sv
module bank_mem_unit
  import bank_mem_pkg::*;
#(
  parameter int GPR_TOP = 'h1FF
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rdMode,
  input  logic [7:0] rdOpnd,
  output logic [7:0] rdData,
  input  logic       wrEn,
  input  logic [1:0] wrMode,
  input  logic [7:0] wrOpnd,
  input  logic [7:0] wrData
);
  memStrobe_t        strobe;
  logic [DATA_W-1:0] ctrlRdData;
  logic              ctrlRdHit;

  bank_mem_ctrl #(.GPR_TOP(GPR_TOP)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rdMode(rdMode), .rdOpnd(rdOpnd),
    .wrEn(wrEn), .wrMode(wrMode), .wrOpnd(wrOpnd), .wrData(wrData),
    .strobe(strobe), .ctrlRdData(ctrlRdData), .ctrlRdHit(ctrlRdHit)
  );

  bank_mem_dpath #(.GPR_TOP(GPR_TOP)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .ctrlRdData(ctrlRdData), .ctrlRdHit(ctrlRdHit), .rdData(rdData)
  );
endmodule

// File: tb/bank_mem_unit_tb.sv
module bank_mem_unit_tb;
  localparam int TOP = 'h17F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rdMode = '0;
  logic [7:0] rdOpnd = '0;
  logic [7:0] rdData;
  logic       wrEn = 1'b0;
  logic [1:0] wrMode = '0;
  logic [7:0] wrOpnd = '0;
  logic [7:0] wrData = '0;

  int vectors = 0;
  int fails = 0;

  logic [3:0]  mBsel;
  logic [11:0] mPtr;
  logic [7:0]  mMem [TOP+1];

  always #2 clk = ~clk;

  bank_mem_unit #(.GPR_TOP(TOP)) u_dut (
    .clk(clk), .rstN(rstN), .rdMode(rdMode), .rdOpnd(rdOpnd), .rdData(rdData),
    .wrEn(wrEn), .wrMode(wrMode), .wrOpnd(wrOpnd), .wrData(wrData)
  );

  function automatic logic [11:0] mAddr(input logic [1:0] m, input logic [7:0] o);
    if (m == 2'd1) return o[7] ? {4'hF, o} : {4'h0, o};  // R2
    if (m == 2'd2) return mPtr;                           // R3
    return {mBsel, o};                                    // R1
  endfunction

  function automatic logic [7:0] mRead(input logic [11:0] a);
    if (a <= 12'(TOP)) return mMem[a];
    if (a == 12'hFE0) return {4'h0, mBsel};
    if (a == 12'hFE9) return mPtr[7:0];
    if (a == 12'hFEA) return {4'h0, mPtr[11:8]};
    return 8'h00;                                         // R5
  endfunction

  task automatic mWrite(input logic [11:0] a, input logic [7:0] d);
    if (a <= 12'(TOP)) mMem[a] = d;
    else if (a == 12'hFE0) mBsel = d[3:0];
    else if (a == 12'hFE9) mPtr[7:0] = d;
    else if (a == 12'hFEA) mPtr[11:8] = d[3:0];
  endtask

  task automatic step(input logic [1:0] rm, input logic [7:0] ro, input logic we,
                      input logic [1:0] wm, input logic [7:0] wo, input logic [7:0] wd,
                      input string tag);
    logic [7:0] exp;
    logic [11:0] wa;
    @(negedge clk);
    rdMode = rm; rdOpnd = ro; wrEn = we; wrMode = wm; wrOpnd = wo; wrData = wd;
    #1;
    exp = mRead(mAddr(rm, ro));
    wa = mAddr(wm, wo);
    vectors++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: mode %0d opnd %h got %h expected %h", tag, rm, ro, rdData, exp);
    end
    @(posedge clk);
    if (we) mWrite(wa, wd);
  endtask

  function automatic string tagOf(input logic [1:0] m, input logic [7:0] o);
    logic [11:0] a = mAddr(m, o);
    if (a > 12'(TOP) && a != 12'hFE0 && a != 12'hFE9 && a != 12'hFEA) return "R5";
    if (m == 2'd1) return "R2";
    if (m == 2'd2) return "R3";
    return "R1";
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd8112);
    mBsel = '0; mPtr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: control registers are zero after reset
    step(2'd1, 8'hE0, 1'b0, 2'd0, 8'h00, 8'h00, "R8");
    step(2'd1, 8'hE9, 1'b0, 2'd0, 8'h00, 8'h00, "R8");
    step(2'd1, 8'hEA, 1'b0, 2'd0, 8'h00, 8'h00, "R8");

    // fill RAM: bank 0 through direct, bank 1 through direct with bsel=1
    for (int i = 0; i < 256; i++) step(2'd1, 8'hE0, 1'b1, 2'd0, 8'(i), 8'($urandom), "R7");
    step(2'd1, 8'hE0, 1'b1, 2'd1, 8'hE0, 8'hF1, "R4");
    step(2'd1, 8'hE0, 1'b0, 2'd0, 8'h00, 8'h00, "R4");     // reads 0x01
    for (int i = 0; i < 128; i++) step(2'd0, 8'(i), 1'b1, 2'd0, 8'(i), 8'($urandom), "R7");
    for (int i = 0; i < 128; i++) step(2'd0, 8'(i), 1'b0, 2'd0, 8'h00, 8'h00, "R1");

    // R5 boundary in bank 1: 0x17F implemented, 0x180 not
    step(2'd0, 8'h7F, 1'b0, 2'd0, 8'h00, 8'h00, "R1");
    step(2'd0, 8'h80, 1'b0, 2'd0, 8'h00, 8'h00, "R5");
    step(2'd3, 8'h7F, 1'b0, 2'd0, 8'h00, 8'h00, "R1");
    // R6: write to 0x180 must not alias onto low RAM
    step(2'd0, 8'h80, 1'b1, 2'd0, 8'h80, 8'hAA, "R6");
    step(2'd1, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, "R6");
    step(2'd0, 8'h00, 1'b1, 2'd0, 8'hF0, 8'h5A, "R6");
    step(2'd2, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, "R6");
    step(2'd1, 8'h80, 1'b0, 2'd0, 8'h00, 8'h00, "R5");
    step(2'd1, 8'hE1, 1'b1, 2'd1, 8'hE1, 8'h77, "R5");
    step(2'd1, 8'hE1, 1'b0, 2'd0, 8'h00, 8'h00, "R6");
    // R7: write enable low leaves RAM alone
    step(2'd0, 8'h10, 1'b0, 2'd0, 8'h10, 8'hC3, "R7");
    step(2'd0, 8'h10, 1'b0, 2'd0, 8'h00, 8'h00, "R7");
    // R9: same-cycle readback returns old bsel, new bank used next cycle
    step(2'd1, 8'hE0, 1'b1, 2'd1, 8'hE0, 8'h00, "R9");
    step(2'd0, 8'h10, 1'b0, 2'd0, 8'h00, 8'h00, "R9");
    // R3: pointer high nibble discarded, pointer used without banking
    step(2'd1, 8'hEA, 1'b1, 2'd1, 8'hEA, 8'hF1, "R3");
    step(2'd1, 8'hEA, 1'b1, 2'd1, 8'hE9, 8'h7F, "R3");
    step(2'd2, 8'h33, 1'b0, 2'd0, 8'h00, 8'h00, "R3");
    step(2'd1, 8'hE9, 1'b1, 2'd1, 8'hE9, 8'h80, "R9");
    step(2'd2, 8'h00, 1'b0, 2'd0, 8'h00, 8'h00, "R5");
    // R2: access mode ignores bank select
    step(2'd1, 8'hE0, 1'b1, 2'd1, 8'hE0, 8'h0F, "R4");
    step(2'd1, 8'h05, 1'b0, 2'd0, 8'h00, 8'h00, "R2");
    step(2'd1, 8'hE0, 1'b0, 2'd0, 8'h00, 8'h00, "R2");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] rm, wm;
      logic [7:0] ro, wo, wd;
      logic we;
      int sel;
      rm = 2'($urandom); ro = 8'($urandom);
      wm = 2'($urandom); wo = 8'($urandom); wd = 8'($urandom);
      we = 1'($urandom);
      sel = $urandom % 10;
      if (sel == 0) begin wm = 2'd1; wo = 8'hE0; wd = {4'($urandom), 3'b000, 1'($urandom)}; end
      else if (sel == 1) begin wm = 2'd1; wo = 8'hE9; end
      else if (sel == 2) begin wm = 2'd1; wo = 8'hEA; wd = {4'($urandom), 3'b000, 1'($urandom)}; end
      if (rm == 2'd1 && ($urandom % 3) == 0) ro = {3'b111, 1'b0, 2'b10, 1'($urandom), 1'($urandom)};
      step(rm, ro, we, wm, wo, wd, tagOf(rm, ro));
    end

    summary();
    $finish;
  end
endmodule